// File: doc/BRIEF.md
# Dual Strobed Two-to-Four Demultiplexer

This block holds two one-to-four demultiplexer sections behind a single two-bit address. Each section has its own active-low enable and its own data input, and drives four active-low output lines. An output line goes low only when all of these hold:

- its section is enabled;
- the section's data input is at its asserting level;
- the address points at that line.

Every other output line stays high. The block is purely combinational. The outputs follow the present inputs, and the block holds no state.

The two data inputs have opposite senses. Section one asserts when its data is high. Section two asserts when its data is low. If both data pins are tied to one line and both enables to one strobe, that shared data line works as a third address bit, and the pair becomes a one-of-eight decoder with no extra gate. The wrapper `demux_1of8` makes these ties and presents the eight lines as one active-low bus.

Top module: `demux_pair`

## Requirements
- R1: The two-bit address `sel` is shared by both sections, with `sel[1]` as the most significant bit. Address value k (0 to 3) selects output bit k of each group.
- R2: All outputs are active low. An output that is not addressed, or that belongs to a disabled section, is 1.
- R3: While a section's enable input is 1, all four bits of that section's group are 1, whatever the data and address are.
- R4: Section one asserts on data high. With `stb1_n` = 0 and `din1` = 1, the addressed bit of `grp1_n` is 0. With `din1` = 0, `grp1_n` is 4'b1111.
- R5: Section two asserts on data low. With `stb2_n` = 0 and `din2` = 0, the addressed bit of `grp2_n` is 0. With `din2` = 1, `grp2_n` is 4'b1111.
- R6: The enable and data input of one section have no effect on the other section's outputs.
- R7: In the cascade wrapper, with the strobe at 0, the 3-bit code {`addr_hi`, `sel`} drives `line_n[code]` to 0. Code 0 to 3 comes from section two and code 4 to 7 from section one, so `line_n` = {section one group, section two group}.
- R8: In the cascade wrapper, while the strobe is 1, all eight lines are 1.
- R9: At most one output per section is 0 at any time, and at most one of the eight cascade lines is 0 at any time.
- R10: The outputs depend only on the present inputs. Applying the same input combination again gives the same outputs, whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 2 | Shared address; bit 1 is the MSB |
| stb1_n | input | 1 | Active-low enable of section one |
| stb2_n | input | 1 | Active-low enable of section two |
| din1 | input | 1 | Section one data; asserts when high |
| din2 | input | 1 | Section two data; asserts when low |
| grp1_n | output | 4 | Section one outputs, active low |
| grp2_n | output | 4 | Section two outputs, active low |

## Verification
The assertions are immediate checks on combinational outputs. They assume every input holds a defined 0 or 1, and that they are evaluated after the inputs have settled. The bench drives each input combination once per clock period at one edge and reads the outputs half a period later. It never leaves an input undriven, so every evaluation sees a complete, stable input vector. All 64 combinations of the pair and all 16 combinations of the wrapper are covered. The address, strobe and data inputs are always driven together.

// File: rtl/demux_pkg.sv
// Package: shared types for the strobed demultiplexer pair.
// Assumes: nothing beyond standard SystemVerilog.
package demux_pkg;

    // Sense of a section's data input: which level asserts the addressed line.
    typedef enum logic {
        POL_ASSERT_HIGH = 1'b0,
        POL_ASSERT_LOW  = 1'b1
    } data_pol_e;

    // Width of the shared address.
    localparam int ADDR_W = 2;

endpackage

// File: rtl/demux_section.sv
// Module: demux_section
// One enabled one-to-N demultiplexer with active-low outputs. The data
// sense is chosen by parameter, which lets two sections of opposite
// sense cascade into a wider decoder.
// Assumes: inputs are defined 0/1 levels; the block has no clock or state.
module demux_section #(
    parameter int                  SEL_W = demux_pkg::ADDR_W,
    parameter demux_pkg::data_pol_e POL  = demux_pkg::POL_ASSERT_HIGH,
    localparam int                 OUTS  = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             strobe_n,
    input  logic             din,
    output logic [OUTS-1:0]  out_n
);

    logic data_active;
    logic route_en;

    // Pick the data sense given by POL.
    generate
        if (POL == demux_pkg::POL_ASSERT_HIGH) begin : g_pos
            assign data_active = din;
        end else begin : g_neg
            assign data_active = ~din;
        end
    endgenerate

    // The section routes only while enabled and the data asserts.
    assign route_en = ~strobe_n & data_active;

    // Drive the addressed line low; all others stay high.
    always_comb begin
        for (int i = 0; i < OUTS; i++) begin
            out_n[i] = ~(route_en && (sel == SEL_W'(i)));
        end
    end

    // Guard the output group against multiple lows and a leaky enable.
    always_comb begin
        AST_SECTION_ONE_LOW: assert ($countones(~out_n) <= 1);                // R9
        if (strobe_n) begin
            AST_SECTION_STROBE_OFF: assert (out_n == {OUTS{1'b1}});           // R3
        end
    end

endmodule

// File: rtl/demux_1of8.sv
// Module: demux_1of8
// Cascade wrapper. Ties the enables of both sections to one strobe and
// both data inputs to one line that acts as the address MSB, giving
// eight active-low lines.
// Assumes: inputs are defined 0/1 levels; purely combinational.
module demux_1of8 #(
    parameter int  SEL_W = demux_pkg::ADDR_W,
    localparam int LINES = 2 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             strobe_n,
    input  logic             addr_hi,
    output logic [LINES-1:0] line_n
);

    localparam int HALF = LINES / 2;

    logic [HALF-1:0] hi_half_n;
    logic [HALF-1:0] lo_half_n;

    // The pair itself, with shared strobe and shared data line.
    demux_pair #(.SEL_W(SEL_W)) u_pair (
        .sel    (sel),
        .stb1_n (strobe_n),
        .stb2_n (strobe_n),
        .din1   (addr_hi),
        .din2   (addr_hi),
        .grp1_n (hi_half_n),
        .grp2_n (lo_half_n)
    );

    // The section that asserts on high data carries the upper lines.
    assign line_n = {hi_half_n, lo_half_n};

    // Guard the cascade: exactly the coded line low when on, none when off.
    always_comb begin
        AST_CASCADE_ONE_LOW: assert ($countones(~line_n) <= 1);               // R9
        if (strobe_n) begin
            AST_CASCADE_OFF: assert (line_n == {LINES{1'b1}});                // R8
        end else begin
            AST_CASCADE_HIT: assert (line_n[{addr_hi, sel}] == 1'b0);         // R7
        end
    end

endmodule

// File: rtl/demux_pair.sv
// Module: demux_pair
// Two one-to-four demultiplexer sections that share one address. Each has
// its own active-low enable. Section one asserts on high data, section two
// on low data.
// Assumes: inputs are defined 0/1 levels; no clock, no state.
module demux_pair #(
    parameter int  SEL_W = demux_pkg::ADDR_W,
    localparam int OUTS  = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             stb1_n,
    input  logic             stb2_n,
    input  logic             din1,
    input  logic             din2,
    output logic [OUTS-1:0]  grp1_n,
    output logic [OUTS-1:0]  grp2_n
);

    // Section one: the addressed line asserts when data is high.
    demux_section #(.SEL_W(SEL_W), .POL(demux_pkg::POL_ASSERT_HIGH)) u_sec1 (
        .sel      (sel),
        .strobe_n (stb1_n),
        .din      (din1),
        .out_n    (grp1_n)
    );

    // Section two: the addressed line asserts when data is low.
    demux_section #(.SEL_W(SEL_W), .POL(demux_pkg::POL_ASSERT_LOW)) u_sec2 (
        .sel      (sel),
        .strobe_n (stb2_n),
        .din      (din2),
        .out_n    (grp2_n)
    );

    // Cross-check each section's data sense at the pair boundary.
    always_comb begin
        if (!stb1_n && din1) begin
            AST_SEC1_HIT: assert (grp1_n[sel] == 1'b0);                       // R4
        end
        if (!stb2_n && !din2) begin
            AST_SEC2_HIT: assert (grp2_n[sel] == 1'b0);                       // R5
        end
        if (!din1) begin
            AST_SEC1_IDLE: assert (grp1_n == {OUTS{1'b1}});                   // R4
        end
        if (din2) begin
            AST_SEC2_IDLE: assert (grp2_n == {OUTS{1'b1}});                   // R5
        end
    end

endmodule

// File: tb/demux_pair_tb.sv
// Bench: exhaustive check of the demultiplexer pair and the cascade wrapper
// against a behavioural model computed here.
module demux_pair_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       stb1_n = 1'b1, stb2_n = 1'b1, din1 = 1'b0, din2 = 1'b1;
    logic [3:0] grp1_n, grp2_n;
    logic [1:0] c_sel = 2'b00;
    logic       c_strobe_n = 1'b1, c_hi = 1'b0;
    logic [7:0] line_n;

    int checks = 0;
    int errors = 0;
    logic [3:0] g1_keep [64];
    logic [3:0] g2_keep [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    demux_pair u_dut (
        .sel(sel), .stb1_n(stb1_n), .stb2_n(stb2_n), .din1(din1), .din2(din2),
        .grp1_n(grp1_n), .grp2_n(grp2_n)
    );

    demux_1of8 u_cascade (
        .sel(c_sel), .strobe_n(c_strobe_n), .addr_hi(c_hi), .line_n(line_n)
    );

    // One compare: count it, and report a mismatch with its requirement.
    task automatic expect_val(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Count the zero bits of a group.
    function automatic int lows(input logic [7:0] v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (v[i] == 1'b0) c++;
        return c;
    endfunction

    // Apply one pair vector at a rising edge; the caller samples at the falling edge.
    task automatic drive_pair(input int code);
        @(posedge clk);
        stb1_n = code[5]; stb2_n = code[4]; din1 = code[3]; din2 = code[2];
        sel = code[1:0];
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Idle state: both sections disabled.
        @(negedge clk);
        expect_val("R3 idle grp1", {4'h0, grp1_n}, 8'h0F);
        expect_val("R3 idle grp2", {4'h0, grp2_n}, 8'h0F);

        // Exhaustive pair sweep against the model.
        for (int code = 0; code < 64; code++) begin
            int a;
            logic [3:0] e1, e2;
            string t1, t2;
            drive_pair(code);
            a  = code & 3;
            e1 = 4'hF;
            e2 = 4'hF;
            if (code[5] == 1'b0 && code[3] == 1'b1) e1[a] = 1'b0;
            if (code[4] == 1'b0 && code[2] == 1'b0) e2[a] = 1'b0;
            t1 = code[5] ? "R3 grp1 disabled" : (code[3] ? "R4 R1 R2 grp1 addressed" : "R4 grp1 data idle");
            t2 = code[4] ? "R3 grp2 disabled" : (!code[2] ? "R5 R1 R2 grp2 addressed" : "R5 grp2 data idle");
            expect_val(t1, {4'h0, grp1_n}, {4'h0, e1});
            expect_val(t2, {4'h0, grp2_n}, {4'h0, e2});
            expect_val("R9 grp1 lows", 8'(lows({4'hF, grp1_n}, 4) <= 1), 8'd1);
            expect_val("R9 grp2 lows", 8'(lows({4'hF, grp2_n}, 4) <= 1), 8'd1);
            g1_keep[code] = grp1_n;
            g2_keep[code] = grp2_n;
        end

        // R6: vary one section's enable and data; the other group must not move.
        for (int code = 0; code < 64; code++) begin
            int other;
            other = code ^ 6'b101000;
            drive_pair(other);
            expect_val("R6 grp2 unaffected by section one", {4'h0, grp2_n}, {4'h0, g2_keep[code]});
            other = code ^ 6'b010100;
            drive_pair(other);
            expect_val("R6 grp1 unaffected by section two", {4'h0, grp1_n}, {4'h0, g1_keep[code]});
        end

        // R10: replay in reverse order; outputs must match the first pass.
        for (int code = 63; code >= 0; code--) begin
            drive_pair(code);
            expect_val("R10 replay grp1", {4'h0, grp1_n}, {4'h0, g1_keep[code]});
            expect_val("R10 replay grp2", {4'h0, grp2_n}, {4'h0, g2_keep[code]});
        end

        // Cascade sweep over strobe, high address bit and shared address.
        for (int code = 0; code < 16; code++) begin
            logic [7:0] e;
            @(posedge clk);
            c_strobe_n = code[3]; c_hi = code[2]; c_sel = code[1:0];
            @(negedge clk);
            e = 8'hFF;
            if (!code[3]) e[code & 7] = 1'b0;
            expect_val(code[3] ? "R8 cascade off" : "R7 cascade line", line_n, e);
            expect_val("R9 cascade lows", 8'(lows(line_n, 8) <= 1), 8'd1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule